// File: doc/BRIEF.md
# Ping-Pong Stack Sample Order Reverser

This unit turns blocks of 12-bit samples around, so that each block leaves in the opposite order to the one it arrived in. It serves the return path of a folded FIR delay line. It holds two stacks that swap roles. While one stack collects the current block, the other plays back the previous block, newest sample first. An external block strobe marks where each block ends. The stacks trade places on each high-to-low transition of that strobe. Under decimation by N, the strobe drops once every N clock cycles, so a block is as long as the strobe period.

A reversal-enable input selects the mode. With it cleared, the unit is a one-stage delay register and samples pass in arrival order. Reversal must be off when interleaved data runs through the filter. Changing to delay mode empties both stacks, so old data is never replayed. A clock enable freezes all state. If a block holds more samples than a stack can store, the oldest samples are lost and an overflow flag is raised for the rest of that block.

Top module: `order_reverser`

## Requirements
- R1: While reset is asserted, and after it is released, `dout` is 0 and `ovf` is 0 until a sample is produced.
- R2: In reverse mode, the samples pushed between two strobe falls come out in reverse order. On the clock edge that sees the closing fall, `dout` takes the last sample of the block. Each following enabled edge gives the next older sample.
- R3: In reverse mode, once the stack being played back is exhausted, `dout` is 0 on every enabled edge until the next swap.
- R4: The stacks swap roles only on an enabled edge where the registered strobe is 1 and the live strobe is 0. A strobe held low or a rising strobe causes no swap. The sample presented on a swap edge is the first sample of the new block.
- R5: Each stack holds DEPTH entries (default 16). Pushing more than DEPTH samples into one block keeps only the newest DEPTH. `ovf` goes to 1 on the edge that pushes sample DEPTH+1 and returns to 0 on the next swap edge.
- R6: With `rev_en` = 0, each enabled edge loads `dout` with the `din` present at that edge.
- R7: An enabled edge with `rev_en` = 0 empties both stacks and clears `ovf`. After a return to reverse mode, `dout` is 0 until the first swap.
- R8: With `clk_en` = 0, `dout`, `ovf`, the stacks and the registered strobe all hold their values. A strobe fall that happens while the clock is disabled takes effect on the next enabled edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Clock enable; when 0, all state holds |
| rev_en | input | 1 | 1 = reverse blocks, 0 = one-stage delay |
| blk_strobe | input | 1 | Block strobe; a high-to-low transition ends a block |
| din | input | 12 | Input sample |
| dout | output | 12 | Output sample, registered |
| ovf | output | 1 | Current block has exceeded the stack depth |

## Verification
On every swap edge, two functions happen in the same cycle. The new filling stack is cleared and takes its first sample, while the just-completed stack begins playback. The vector table closes blocks of 4, 5 and 3 samples. After each strobe fall, the first output must be the newest sample of the closed block. No sample from the new block may leak into that output.

A second collision comes from dropping the strobe while `clk_en` is low. The swap must then happen on the next enabled edge, and it must coincide with that edge's push.

// File: rtl/rev_order_pkg.sv
package rev_order_pkg;

  typedef enum logic {
    MODE_DELAY   = 1'b0,
    MODE_REVERSE = 1'b1
  } rev_mode_e;

  // Ring pointer advance modulo depth
  function automatic int unsigned ring_next(input int unsigned p, input int unsigned depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction

  // Ring pointer retreat modulo depth
  function automatic int unsigned ring_prev(input int unsigned p, input int unsigned depth);
    return (p == 0) ? depth - 1 : p - 1;
  endfunction

  // Occupancy after a push; saturates at depth (oldest entry overwritten)
  function automatic int unsigned occ_after_push(input int unsigned c, input int unsigned depth);
    return (c >= depth) ? depth : c + 1;
  endfunction

endpackage

// File: rtl/rev_strobe_edge.sv
module rev_strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_en,
  input  logic strobe,
  output logic fall
);

  logic strobe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      strobe_q <= 1'b0;
    else if (clk_en) strobe_q <= strobe;
  end

  assign fall = clk_en && strobe_q && !strobe;

  // R8: registered strobe frozen while the clock is disabled
  p_strobe_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> $stable(strobe_q));

endmodule

// File: rtl/rev_lifo.sv
module rev_lifo #(
  parameter int W     = 12,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] top,
  output logic         empty,
  output logic         full
);
  import rev_order_pkg::*;

  localparam int AW = (DEPTH > 2) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp;
  logic [CW-1:0] occ;
  logic [AW-1:0] wp_next, wp_prev;

  assign wp_next = AW'(ring_next(int'(wp), DEPTH));
  assign wp_prev = AW'(ring_prev(int'(wp), DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      occ <= '0;
    end else if (push) begin
      wp  <= wp_next;
      occ <= clr ? CW'(1) : CW'(occ_after_push(int'(occ), DEPTH));
    end else if (clr) begin
      occ <= '0;
    end else if (pop && occ != '0) begin
      wp  <= wp_prev;
      occ <= occ - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  assign top   = mem[wp_prev];
  assign empty = (occ == '0);
  assign full  = (occ == CW'(DEPTH));

  // R5: occupancy never exceeds the stack depth
  p_occ_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH));
  // R2: one stack never fills and drains in the same cycle
  p_push_pop_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop));
  // R3: the controller only pops a stack holding data
  p_pop_nonempty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/order_reverser.sv
module order_reverser #(
  parameter int W     = 12,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clk_en,
  input  logic         rev_en,
  input  logic         blk_strobe,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         ovf
);
  import rev_order_pkg::*;

  localparam int NSTK = 2;

  rev_mode_e     mode;
  logic          fall_evt;
  logic          sel;
  logic          fill_idx, drain_idx;
  logic [NSTK-1:0] push_v, pop_v, clr_v, empty_v, full_v;
  logic [W-1:0]  top_v [NSTK];
  logic [W-1:0]  drain_word;
  logic          ovf_evt;

  assign mode = rev_mode_e'(rev_en);

  rev_strobe_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .clk_en (clk_en),
    .strobe (blk_strobe),
    .fall   (fall_evt)
  );

  for (genvar g = 0; g < NSTK; g++) begin : g_stk
    rev_lifo #(.W(W), .DEPTH(DEPTH)) u_stk (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr_v[g]),
      .push  (push_v[g]),
      .pop   (pop_v[g]),
      .din   (din),
      .top   (top_v[g]),
      .empty (empty_v[g]),
      .full  (full_v[g])
    );
  end

  always_comb begin
    fill_idx  = fall_evt ? ~sel : sel;
    drain_idx = ~fill_idx;
    push_v = '0;
    pop_v  = '0;
    clr_v  = '0;
    if (clk_en) begin
      if (mode == MODE_REVERSE) begin
        push_v[fill_idx]  = 1'b1;
        clr_v[fill_idx]   = fall_evt;
        pop_v[drain_idx]  = !empty_v[drain_idx];
      end else begin
        clr_v = '1;
      end
    end
    drain_word = empty_v[drain_idx] ? '0 : top_v[drain_idx];
    ovf_evt    = clk_en && (mode == MODE_REVERSE) && !fall_evt && full_v[fill_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel  <= 1'b0;
      dout <= '0;
      ovf  <= 1'b0;
    end else if (clk_en) begin
      if (mode == MODE_REVERSE) begin
        sel  <= fill_idx;
        dout <= drain_word;
        if (fall_evt)     ovf <= 1'b0;
        else if (ovf_evt) ovf <= 1'b1;
      end else begin
        dout <= din;
        ovf  <= 1'b0;
      end
    end
  end

  // R4: roles change only after a detected strobe fall
  p_swap_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != $past(sel)) |-> $past(fall_evt));
  // R2: at most one stack fills per cycle
  p_one_filler_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(push_v) <= 1);
  // R6: delay mode forwards the sample one edge later
  p_delay_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !rev_en) |=> (dout == $past(din)));
  // R3: exhausted playback gives zero
  p_drained_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && rev_en && empty_v[drain_idx]) |=> (dout == '0));
  // R7: delay mode leaves both stacks empty
  p_clear_on_delay_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !rev_en) |=> (empty_v == '1));
  // R5: a swap or delay mode drops the overflow flag
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && (fall_evt || !rev_en)) |=> !ovf);
  // R8: nothing moves with the clock disabled
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> ($stable(dout) && $stable(sel) && $stable(ovf)));

endmodule

// File: tb/order_reverser_test.sv
module order_reverser_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk_en = 1'b1;
  logic        rev_en = 1'b1;
  logic        blk_strobe = 1'b1;
  logic [11:0] din = '0;
  logic [11:0] dout;
  logic        ovf;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  order_reverser uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_en     (clk_en),
    .rev_en     (rev_en),
    .blk_strobe (blk_strobe),
    .din        (din),
    .dout       (dout),
    .ovf        (ovf)
  );

  // {clk_en, rev_en, strobe, din, expected dout}
  localparam int NV = 29;
  localparam logic [26:0] VEC [NV] = '{
    {1'b1,1'b1,1'b1,12'h011,12'h000},  // R3 nothing played back yet
    {1'b1,1'b1,1'b1,12'h012,12'h000},
    {1'b1,1'b1,1'b1,12'h013,12'h000},
    {1'b1,1'b1,1'b1,12'h014,12'h000},
    {1'b1,1'b1,1'b0,12'h021,12'h014},  // R2 swap, newest first
    {1'b1,1'b1,1'b1,12'h022,12'h013},
    {1'b1,1'b1,1'b1,12'h023,12'h012},
    {1'b1,1'b1,1'b1,12'h024,12'h011},
    {1'b1,1'b1,1'b0,12'h031,12'h024},  // R2
    {1'b1,1'b1,1'b0,12'h032,12'h023},  // R4 held low: no swap
    {1'b1,1'b1,1'b1,12'h033,12'h022},  // R4 rising: no swap
    {1'b1,1'b1,1'b1,12'h034,12'h021},
    {1'b1,1'b1,1'b1,12'h035,12'h000},  // R3 exhausted
    {1'b1,1'b1,1'b0,12'h041,12'h035},
    {1'b0,1'b1,1'b1,12'h042,12'h035},  // R8 hold
    {1'b1,1'b1,1'b1,12'h043,12'h034},
    {1'b1,1'b1,1'b1,12'h044,12'h033},
    {1'b1,1'b1,1'b0,12'h051,12'h044},
    {1'b1,1'b1,1'b1,12'h052,12'h043},
    {1'b1,1'b0,1'b1,12'h060,12'h060},  // R6 delay mode
    {1'b1,1'b0,1'b1,12'h061,12'h061},  // R6
    {1'b1,1'b1,1'b1,12'h071,12'h000},  // R7 no stale data
    {1'b1,1'b1,1'b1,12'h072,12'h000},  // R7
    {1'b1,1'b1,1'b0,12'h081,12'h072},
    {1'b1,1'b1,1'b1,12'h082,12'h071},
    {1'b1,1'b1,1'b1,12'h083,12'h000},
    {1'b0,1'b1,1'b0,12'h099,12'h000},  // R8 fall while disabled
    {1'b1,1'b1,1'b0,12'h084,12'h083},  // R8 deferred swap
    {1'b1,1'b1,1'b1,12'h085,12'h082}
  };

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic ce, input logic re, input logic sb, input logic [11:0] d);
    clk_en = ce; rev_en = re; blk_strobe = sb; din = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(dout == 12'h000 && ovf == 1'b0, "R1", {ovf, dout}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][26], VEC[i][25], VEC[i][24], VEC[i][23:12]);
      chk(dout == VEC[i][11:0], $sformatf("R2 vector %0d", i), dout, VEC[i][11:0]);
      chk(ovf == 1'b0, $sformatf("R5 vector %0d ovf", i), ovf, 0);
    end

    // R1: mid-run reset clears output
    rst_n = 1'b0;
    #1;
    chk(dout == 12'h000 && ovf == 1'b0, "R1 async", {ovf, dout}, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R5: block of 20 into a 16-deep stack
    for (int i = 0; i < 20; i++) begin
      step(1'b1, 1'b1, 1'b1, 12'(i + 1));
      if (i == 15) chk(ovf == 1'b0, "R5 at depth", ovf, 0);
      if (i == 16) chk(ovf == 1'b1, "R5 overflow", ovf, 1);
    end
    step(1'b1, 1'b1, 1'b0, 12'hA00);
    chk(dout == 12'd20, "R5 newest kept", dout, 20);
    chk(ovf == 1'b0, "R5 flag cleared on swap", ovf, 0);
    for (int k = 1; k < 16; k++) begin
      step(1'b1, 1'b1, 1'b1, 12'h000);
      chk(dout == 12'(20 - k), "R5 playback", dout, 20 - k);
    end
    step(1'b1, 1'b1, 1'b1, 12'h000);
    chk(dout == 12'h000, "R5 oldest dropped", dout, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule